// File: doc/BRIEF.md
# Processor Bus Slave with Burst Sequencing

This block is a slave on a 32-bit processor bus. It gives the bus master access to a small internal word store through single transfers of a byte, a half-word or a word, and through bursts of four words. The slave answers each data beat with an active-low acknowledge. A transfer starts when the slave sees its two select lines in the selecting combination. A direction input chooses read or write, and an 18-bit address gives the low-order part of the master's byte address. The address bits are numbered big-endian, so bit 0 is the most significant bit and bit 17 is the least significant.

A 2-bit size code and the two lowest address bits together choose the big-endian byte lanes that a write touches. The size codes are not in numeric order. A burst always moves whole words. Its word address steps by one on each beat and wraps inside the aligned four-word block. The master keeps a burst going by holding a continuation input high. If it drops that input, the remaining beats are cancelled. Once a transfer ends, the slave waits for the select to be released before it accepts another one.

Top module: `pbus_slave`

## Requirements
- R1: A transfer starts only when `sel0_n` is 0 and `sel1` is 1. With any other select combination there is no acknowledge and the store is not written.
- R2: For a single write (`burst_n`=1, `rd_nwr`=0), `ack_n` is low for exactly one cycle. That cycle is the one that follows the clock edge at which the select was first seen. The write takes effect at that edge.
- R3: For a single read (`rd_nwr`=1), `rdata` holds the addressed word in the cycle where `ack_n` is low, and it keeps that value until the next read.
- R4: The size code chooses the lanes: 01 is a byte, 10 is a half-word and 00 is a word. The byte offset is `addr[16:17]`. Offset 0 maps to `wdata[31:24]` and offset 3 maps to `wdata[7:0]`. A half-word uses only `addr[16]`: 0 selects `[31:16]` and 1 selects `[15:0]`. A word ignores the offset. Lanes that are not selected keep their stored contents. A read always returns the whole word.
- R5: The size code 11 is an error. There is no acknowledge and no write.
- R6: With `burst_n`=0 a transfer is a burst of up to four full-word beats, acknowledged on consecutive cycles. Beat k uses word address (start & ~3) | ((start + k) & 3). The word address is `addr[0:15]`.
- R7: A beat after the first is performed only when `cont` is 1 and the select is still present at its clock edge. Otherwise the burst is aborted, and no further beats are acknowledged or written.
- R8: After a transfer (or an error) ends, the slave stays quiet while the select is held. It accepts a new transfer only after it has seen the select released.
- R9: During reset and in the cycle after it, `ack_n` is 1. Reset also clears `rdata` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel0_n | input | 1 | Select line, active low |
| sel1 | input | 1 | Select line, active high |
| rd_nwr | input | 1 | 1 for read, 0 for write |
| addr | input | 18 | Byte address, bits [0:17], bit 17 least significant |
| size | input | 2 | Size code: 01 byte, 10 half-word, 00 word, 11 error |
| burst_n | input | 1 | 0 marks a burst transfer |
| cont | input | 1 | Burst continuation request |
| wdata | input | 32 | Write data, big-endian lanes |
| rdata | output | 32 | Read data |
| ack_n | output | 1 | Beat acknowledge, active low |

## Verification
The bench writes partial words at each byte and half-word offset. It reads them back to catch lanes that are swapped or reversed, an odd half-word offset that is not ignored, and size codes decoded in numeric order. Word bursts start in the middle of a block to expose an address that runs past the block instead of wrapping. Aborted bursts expose a design that keeps writing or acknowledging after the continuation drops. Held selects and wrong select combinations catch a slave that acknowledges twice or answers when it is not selected, and an error-size transfer must leave the store unchanged.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    localparam int LANES   = 4;
    localparam int BEATS   = 4;
    localparam int BEAT_W  = $clog2(BEATS);

    typedef enum logic [1:0] {
        SZ_WORD = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_HALF = 2'b10,
        SZ_BAD  = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BURST,
        ST_HOLD
    } st_e;

    typedef struct packed {
        logic             en;
        logic             wr;
        logic [LANES-1:0] be;
    } req_t;

    // Big-endian lane mask: be[3] is wdata[31:24] (offset 0).
    function automatic logic [LANES-1:0] lane_mask(size_e sz, logic [1:0] off);
        logic [LANES-1:0] m;
        case (sz)
            SZ_BYTE: m = 4'b1000 >> off;
            SZ_HALF: m = off[1] ? 4'b0011 : 4'b1100;
            SZ_WORD: m = 4'b1111;
            default: m = 4'b0000;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pbus_decode.sv
module pbus_decode
    import pbus_pkg::*;
(
    input  logic             sel0_n,
    input  logic             sel1,
    input  logic [1:0]       size_raw,
    input  logic [1:0]       offset,
    output logic             hit,
    output logic             bad,
    output logic [LANES-1:0] be
);
    size_e sz;

    always_comb begin
        sz  = size_e'(size_raw);
        hit = !sel0_n && sel1;
        bad = (sz == SZ_BAD);
        be  = lane_mask(sz, offset);
    end
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
    import pbus_pkg::*;
#(
    parameter int WORD_AW = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hit,
    input  logic               bad,
    input  logic               rd,
    input  logic               burst_n,
    input  logic               cont,
    input  logic [WORD_AW-1:0] word_addr,
    input  logic [LANES-1:0]   be_in,
    output req_t               req,
    output logic [WORD_AW-1:0] mem_addr,
    output logic               ack_n,
    output st_e                st
);
    st_e                st_nxt;
    logic [BEAT_W-1:0]  cnt_q;
    logic [WORD_AW-1:0] base_q;
    logic               wr_q;
    logic [BEAT_W-1:0]  step;

    always_comb begin
        req      = '0;
        mem_addr = word_addr;
        st_nxt   = st;
        step     = base_q[BEAT_W-1:0] + cnt_q;
        case (st)
            ST_IDLE: begin
                if (hit) begin
                    st_nxt = ST_HOLD;
                    if (!bad) begin
                        req.en = 1'b1;
                        req.wr = !rd;
                        req.be = be_in;
                        if (!burst_n) begin
                            req.be = '1;
                            st_nxt = ST_BURST;
                        end
                    end
                end
            end
            ST_BURST: begin
                mem_addr = {base_q[WORD_AW-1:BEAT_W], step};
                if (hit && cont) begin
                    req.en = 1'b1;
                    req.wr = wr_q;
                    req.be = '1;
                    if (cnt_q == BEAT_W'(BEATS - 1)) st_nxt = ST_HOLD;
                end else begin
                    st_nxt = ST_HOLD;
                end
            end
            default: begin
                if (!hit) st_nxt = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt_q  <= '0;
            base_q <= '0;
            wr_q   <= 1'b0;
            ack_n  <= 1'b1;
        end else begin
            st    <= st_nxt;
            ack_n <= !req.en;
            if (st == ST_IDLE) begin
                cnt_q  <= BEAT_W'(1);
                base_q <= word_addr;
                wr_q   <= !rd;
            end else if (req.en) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pbus_mem.sv
module pbus_mem
    import pbus_pkg::*;
#(
    parameter int WORD_AW = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  req_t               req,
    input  logic [WORD_AW-1:0] addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata
);
    localparam int DEPTH = 1 << WORD_AW;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [7:0] store [DEPTH];
        logic [7:0] q;

        always_ff @(posedge clk) begin
            if (req.en && req.wr && req.be[l]) store[addr] <= wdata[l*8 +: 8];
        end

        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else if (req.en && !req.wr) q <= store[addr];
        end

        assign rdata[l*8 +: 8] = q;
    end
endmodule

// File: rtl/pbus_slave.sv
module pbus_slave
    import pbus_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int WORD_AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel0_n,
    input  logic          sel1,
    input  logic          rd_nwr,
    input  logic [0:17]   addr,
    input  logic [1:0]    size,
    input  logic          burst_n,
    input  logic          cont,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    output logic          ack_n
);
    logic [ADDR_W-1:0]  a_le;
    logic               hit, bad;
    logic [LANES-1:0]   be;
    req_t               mem_req;
    logic [WORD_AW-1:0] mem_addr;
    st_e                st;

    assign a_le = addr;

    pbus_decode u_dec (
        .sel0_n   (sel0_n),
        .sel1     (sel1),
        .size_raw (size),
        .offset   (a_le[1:0]),
        .hit      (hit),
        .bad      (bad),
        .be       (be)
    );

    pbus_seq #(.WORD_AW(WORD_AW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit),
        .bad       (bad),
        .rd        (rd_nwr),
        .burst_n   (burst_n),
        .cont      (cont),
        .word_addr (a_le[WORD_AW+1:2]),
        .be_in     (be),
        .req       (mem_req),
        .mem_addr  (mem_addr),
        .ack_n     (ack_n),
        .st        (st)
    );

    pbus_mem #(.WORD_AW(WORD_AW)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .req   (mem_req),
        .addr  (mem_addr),
        .wdata (wdata),
        .rdata (rdata)
    );
endmodule

// File: rtl/pbus_slave_chk.sv
module pbus_slave_chk
    import pbus_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       sel0_n,
    input logic       sel1,
    input logic [1:0] size,
    input logic       burst_n,
    input logic       cont,
    input logic       ack_n,
    input st_e        st,
    input req_t       req
);
    int acks_seen;

    always_ff @(posedge clk) begin
        if (rst || st == ST_IDLE) acks_seen <= 0;
        else if (!ack_n) acks_seen <= acks_seen + 1;
    end

    AST_ACK_AFTER_SEL: assert property (@(posedge clk) disable iff (rst)
        !ack_n |-> $past(!sel0_n && sel1)); // R1
    AST_BAD_SIZE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !sel0_n && sel1 && size == 2'b11) |=> ack_n); // R5
    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
        (req.en && st == ST_IDLE && burst_n && size == 2'b01) |-> $countones(req.be) == 1); // R4
    AST_BURST_FULL_LANES: assert property (@(posedge clk) disable iff (rst)
        (req.en && st == ST_BURST) |-> req.be == 4'hF); // R6
    AST_BEAT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        acks_seen <= BEATS); // R6
    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BURST && !cont) |=> ack_n); // R7
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD) |=> ack_n); // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> ack_n); // R9
endmodule

bind pbus_slave pbus_slave_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .sel0_n  (sel0_n),
    .sel1    (sel1),
    .size    (size),
    .burst_n (burst_n),
    .cont    (cont),
    .ack_n   (ack_n),
    .st      (st),
    .req     (mem_req)
);

// File: tb/tb_pbus_slave.sv
module tb_pbus_slave;
    logic        clk = 0;
    logic        rst = 1;
    logic        sel0_n = 1, sel1 = 0, rd_nwr = 0, burst_n = 1, cont = 0;
    logic [17:0] addr = '0;
    logic [1:0]  size = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ack_n;
    int          total = 0, bad = 0;

    always #2.5 clk = ~clk;

    pbus_slave dut (.*);

    typedef struct packed {
        logic        rd;
        logic [1:0]  sz;
        logic [17:0] a;
        logic [31:0] wd;
        logic        ack;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VT [NV] = '{
        '{1'b0, 2'b00, 18'h00010, 32'h11223344, 1'b1, 32'h0},
        '{1'b0, 2'b01, 18'h00011, 32'h00AA0000, 1'b1, 32'h0},
        '{1'b1, 2'b00, 18'h00010, 32'h0,        1'b1, 32'h11AA3344},
        '{1'b0, 2'b10, 18'h00012, 32'h0000BEEF, 1'b1, 32'h0},
        '{1'b1, 2'b00, 18'h00013, 32'h0,        1'b1, 32'h11AABEEF},
        '{1'b0, 2'b11, 18'h00010, 32'hFFFFFFFF, 1'b0, 32'h0},
        '{1'b1, 2'b00, 18'h00010, 32'h0,        1'b1, 32'h11AABEEF},
        '{1'b0, 2'b00, 18'h00014, 32'h01020304, 1'b1, 32'h0},
        '{1'b0, 2'b01, 18'h00017, 32'h000000EE, 1'b1, 32'h0},
        '{1'b0, 2'b10, 18'h00015, 32'h99880000, 1'b1, 32'h0},
        '{1'b1, 2'b01, 18'h00014, 32'h0,        1'b1, 32'h998803EE},
        '{1'b1, 2'b11, 18'h00014, 32'h0,        1'b0, 32'h0}
    };

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic single(input logic s0n, input logic s1, input int hold,
                          input logic rd, input logic [1:0] sz, input logic [17:0] a,
                          input logic [31:0] wd, output int acks, output logic first,
                          output logic [31:0] rv);
        @(negedge clk);
        sel0_n = s0n; sel1 = s1; burst_n = 1; cont = 0;
        rd_nwr = rd; size = sz; addr = a; wdata = wd;
        @(negedge clk);
        first = !ack_n; rv = rdata; acks = int'(!ack_n);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            acks += int'(!ack_n);
        end
        sel0_n = 1; sel1 = 0;
        @(negedge clk);
        acks += int'(!ack_n);
    endtask

    task automatic burst(input logic rd, input logic [17:0] a, input logic [31:0] d [4],
                         input int nb, output logic [3:0] ackv, output logic [31:0] rv [4]);
        @(negedge clk);
        sel0_n = 0; sel1 = 1; burst_n = 0; cont = 1;
        rd_nwr = rd; size = 2'b00; addr = a; wdata = d[0];
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            ackv[k] = !ack_n; rv[k] = rdata;
            wdata = d[(k + 1) % 4];
            cont = (k + 1 < nb);
        end
        sel0_n = 1; sel1 = 0; burst_n = 1; cont = 0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%h expected=%h", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int acks;
        logic first;
        logic [31:0] rv;
        logic [3:0]  ackv;
        logic [31:0] rvs [4];
        logic [31:0] da [4];
        logic [31:0] db [4];
        logic [31:0] dz [4];

        da = '{32'hA0A0A0A0, 32'hA1A1A1A1, 32'hA2A2A2A2, 32'hA3A3A3A3};
        db = '{32'hB0B0B0B0, 32'hB1B1B1B1, 32'hB2B2B2B2, 32'hB3B3B3B3};
        dz = '{32'h0, 32'h0, 32'h0, 32'h0};

        // R9: reset state
        repeat (3) @(negedge clk);
        check(ack_n === 1'b1, "R9", "ack_n in reset", 32'(ack_n), 32'h1);
        rst = 0;
        @(negedge clk);
        check(ack_n === 1'b1, "R9", "ack_n after reset", 32'(ack_n), 32'h1);
        check(rdata === 32'h0, "R9", "rdata after reset", rdata, 32'h0);

        // R2 R3 R4 R5: vector table of single transfers
        for (int i = 0; i < NV; i++) begin
            single(1'b0, 1'b1, 1, VT[i].rd, VT[i].sz, VT[i].a, VT[i].wd, acks, first, rv);
            check(acks == int'(VT[i].ack) && first == VT[i].ack, VT[i].ack ? "R2" : "R5",
                  $sformatf("vec %0d ack count", i), 32'(acks), 32'(VT[i].ack));
            if (VT[i].rd && VT[i].ack)
                check(rv === VT[i].exp, "R4", $sformatf("vec %0d read data", i), rv, VT[i].exp);
        end

        // R3: rdata held after read ack
        @(negedge clk);
        check(rdata === 32'h998803EE, "R3", "rdata held", rdata, 32'h998803EE);

        // R1: wrong select combinations neither ack nor write
        single(1'b1, 1'b1, 1, 1'b0, 2'b00, 18'h00010, 32'hDEADDEAD, acks, first, rv);
        check(acks == 0, "R1", "sel0_n high ack", 32'(acks), 32'h0);
        single(1'b0, 1'b0, 1, 1'b0, 2'b00, 18'h00010, 32'hDEADDEAD, acks, first, rv);
        check(acks == 0, "R1", "sel1 low ack", 32'(acks), 32'h0);
        single(1'b0, 1'b1, 1, 1'b1, 2'b00, 18'h00010, 32'h0, acks, first, rv);
        check(rv === 32'h11AABEEF, "R1", "store untouched", rv, 32'h11AABEEF);

        // R8: long-held select gives one ack only
        single(1'b0, 1'b1, 5, 1'b1, 2'b00, 18'h00014, 32'h0, acks, first, rv);
        check(acks == 1 && first, "R8", "held select ack count", 32'(acks), 32'h1);

        // R6: write burst from word 9 wraps 9,10,11,8
        burst(1'b0, 18'h00024, da, 4, ackv, rvs);
        check(ackv == 4'hF, "R6", "write burst acks", 32'(ackv), 32'hF);
        // R6: read burst from word 10 returns 10,11,8,9
        burst(1'b1, 18'h00028, dz, 4, ackv, rvs);
        check(ackv == 4'hF, "R6", "read burst acks", 32'(ackv), 32'hF);
        check(rvs[0] === da[1], "R6", "rd beat0", rvs[0], da[1]);
        check(rvs[1] === da[2], "R6", "rd beat1", rvs[1], da[2]);
        check(rvs[2] === da[3], "R6", "rd beat2 wrap", rvs[2], da[3]);
        check(rvs[3] === da[0], "R6", "rd beat3", rvs[3], da[0]);

        // R7: write burst aborted after two beats
        burst(1'b0, 18'h00020, db, 2, ackv, rvs);
        check(ackv == 4'b0011, "R7", "aborted write acks", 32'(ackv), 32'h3);
        burst(1'b1, 18'h00020, dz, 4, ackv, rvs);
        check(rvs[0] === db[0], "R7", "word8 written", rvs[0], db[0]);
        check(rvs[1] === db[1], "R7", "word9 written", rvs[1], db[1]);
        check(rvs[2] === da[1], "R7", "word10 untouched", rvs[2], da[1]);
        check(rvs[3] === da[2], "R7", "word11 untouched", rvs[3], da[2]);

        // R7: read burst aborted after first beat
        burst(1'b1, 18'h0002C, dz, 1, ackv, rvs);
        check(ackv == 4'b0001, "R7", "aborted read acks", 32'(ackv), 32'h1);
        check(rvs[0] === da[2], "R7", "aborted read beat0", rvs[0], da[2]);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule